// File: doc/BRIEF.md
# Gated Frequency Counter

This block measures how often a digital signal rises. It opens a gate window of known length, counts the rising edges of the input while the window is open, and multiplies that count by a factor chosen so that the result is always in hertz. The window is timed from the block's own reference clock. A free-running power-of-two prescaler splits that clock into timebase ticks, and a window is a whole number of those ticks.

A measurement runs only when it is asked for. A start strobe selects one of three window lengths. The block then clears its edge counter and waits for the next timebase boundary. Only after that does it raise the gate, so a window never opens partway through a tick. When the window closes, the block scales the count and raises a done flag. The result and the overflow flag hold their values until the next start. The input may be asynchronous, because it passes through a two-flop synchronizer and a rising-edge detector before it reaches the counter.

Top module: `freq_counter`

## Requirements
- R1: After reset, `done`, `gate_o` and `overflow` are 0 and `result` is all zeros.
- R2: A `start` pulse is accepted while the block is idle or done. `done` goes low on the next clock and stays low until the new result is ready.
- R3: The gate opens only on the cycle after a timebase tick, where a tick is the last cycle of each 2^TB_SHIFT-cycle prescaler period. It then stays high for exactly TICKS × 2^TB_SHIFT cycles. The `gate_sel` code sets TICKS: 2'b00 gives TICKS_LONG, 2'b01 gives TICKS_MID, 2'b10 gives TICKS_SHORT, and 2'b11 behaves like 2'b00.
- R4: The raw count is the number of synchronized rising edges of `sig_in` that fall inside the gate. A level that stays high, or any activity outside the gate, adds nothing.
- R5: The result is the raw count times a factor. The factor is 1 for codes 2'b00 and 2'b11, SCALE_MID (40) for 2'b01, and SCALE_SHORT (50) for 2'b10.
- R6: If the raw count or the scaled product does not fit in CNT_W bits, `overflow` is 1 and `result` is all ones.
- R7: While `done` is high and no `start` arrives, `done`, `result` and `overflow` do not change.
- R8: During a measurement, `start` pulses and changes on `gate_sel` are ignored. The code captured at the accepted start sets both the window length and the factor.
- R9: Each measurement counts from zero. A later measurement is not affected by an earlier count or overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; it also times the gate |
| rst_n | input | 1 | Asynchronous reset, active low |
| sig_in | input | 1 | Signal to be measured, asynchronous to clk |
| start | input | 1 | One-cycle request to begin a measurement |
| gate_sel | input | 2 | Window length and scale code |
| gate_o | output | 1 | High while the counting window is open |
| done | output | 1 | Result ready; held until the next start |
| overflow | output | 1 | Count or scaled result saturated |
| result | output | CNT_W | Measured frequency in hertz |

## Verification
The bench is built with an 8-bit result and short windows of 800, 20 and 16 cycles. It sweeps every input period that divides each window evenly, for all four select codes. A window of that length always holds exactly window/period rising edges whatever the phase, so the expected count is plain arithmetic. With an 8-bit result, fast inputs drive both the raw count and the scaled product past the top of the range. A design that wraps instead of saturating, or that checks only one of the two limits, returns a small wrong number. Each run also measures how long the gate stays high, so an off-by-one in the tick counter or a wrong window length for a code shows up even when the count would still be right. Stray starts and select changes are injected mid-window to catch a design that re-latches the code. A held-high input catches a design that counts levels instead of edges. A slow measurement run after an overflowing one catches a counter or flag that is not cleared.

// File: rtl/fc_pkg.sv
`timescale 1ns/1ps
package fc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_WAIT,
        ST_GATE,
        ST_SCALE,
        ST_DONE
    } fc_state_e;

    localparam logic [1:0] SEL_LONG  = 2'b00;
    localparam logic [1:0] SEL_MID   = 2'b01;
    localparam logic [1:0] SEL_SHORT = 2'b10;

endpackage

// File: rtl/fc_sync_edge.sv
`timescale 1ns/1ps
module fc_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.s1 = din;
        r_d.s2 = r_q.s1;
        r_d.s3 = r_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rise = r_q.s2 & ~r_q.s3;

    // R4: an edge pulse lasts one cycle, so a held level is not counted twice
    p_rise_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/fc_timebase.sv
`timescale 1ns/1ps
module fc_timebase #(
    parameter int TB_SHIFT = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (TB_SHIFT < 1) ? 1 : TB_SHIFT;

    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign tick = &pre_q;

    // R3: ticks are spaced by the prescaler period, never back to back
    p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/fc_gate_count.sv
`timescale 1ns/1ps
module fc_gate_count #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         sat
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         sat;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (clr) begin
            c_d = '0;
        end else if (inc) begin
            if (&c_q.cnt) c_d.sat = 1'b1;
            else          c_d.cnt = c_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt = c_q.cnt;
    assign sat = c_q.sat;

    // R4: the count moves only on a gated edge or a clear
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> ($stable(cnt) && $stable(sat)));

    // R6: saturation is sticky until the next clear
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sat && !clr) |=> sat);

    // R9: a clear always returns the counter to zero
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && !sat));

endmodule

// File: rtl/freq_counter.sv
`timescale 1ns/1ps
module freq_counter #(
    parameter int CNT_W       = 32,
    parameter int TB_SHIFT    = 3,
    parameter int TICKS_LONG  = 500000,
    parameter int TICKS_MID   = 12500,
    parameter int TICKS_SHORT = 10000,
    parameter int SCALE_MID   = 40,
    parameter int SCALE_SHORT = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic             start,
    input  logic [1:0]       gate_sel,
    output logic             gate_o,
    output logic             done,
    output logic             overflow,
    output logic [CNT_W-1:0] result
);
    import fc_pkg::*;

    localparam int TICK_W = $clog2(TICKS_LONG + 1);
    localparam int FAC_W  = 8;
    localparam int PROD_W = CNT_W + FAC_W;

    typedef struct packed {
        fc_state_e          state;
        logic [1:0]         sel;
        logic [TICK_W-1:0]  ticks;
        logic               ovf;
        logic [CNT_W-1:0]   result;
    } regs_t;

    regs_t r_d, r_q;

    logic             tick;
    logic             rise;
    logic             cnt_clr;
    logic             cnt_inc;
    logic [CNT_W-1:0] cnt;
    logic             cnt_sat;
    logic [FAC_W-1:0] fac;
    logic [PROD_W-1:0] prod;
    logic [TICK_W-1:0] ticks_load;

    fc_sync_edge u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sig_in),
        .rise  (rise)
    );

    fc_timebase #(.TB_SHIFT(TB_SHIFT)) u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    fc_gate_count #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt),
        .sat   (cnt_sat)
    );

    // window length and factor both follow the captured code
    always_comb begin
        case (r_q.sel)
            SEL_MID: begin
                ticks_load = TICK_W'(TICKS_MID);
                fac        = FAC_W'(SCALE_MID);
            end
            SEL_SHORT: begin
                ticks_load = TICK_W'(TICKS_SHORT);
                fac        = FAC_W'(SCALE_SHORT);
            end
            default: begin
                ticks_load = TICK_W'(TICKS_LONG);
                fac        = FAC_W'(1);
            end
        endcase
    end

    assign prod    = {{FAC_W{1'b0}}, cnt} * {{CNT_W{1'b0}}, fac};
    assign cnt_inc = rise && (r_q.state == ST_GATE);

    always_comb begin
        r_d     = r_q;
        cnt_clr = 1'b0;
        case (r_q.state)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    r_d.state = ST_CLEAR;
                    r_d.sel   = gate_sel;
                    r_d.ovf   = 1'b0;
                end
            end
            ST_CLEAR: begin
                cnt_clr   = 1'b1;
                r_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (tick) begin
                    r_d.state = ST_GATE;
                    r_d.ticks = ticks_load;
                end
            end
            ST_GATE: begin
                if (tick) begin
                    if (r_q.ticks <= TICK_W'(1)) r_d.state = ST_SCALE;
                    else                         r_d.ticks = r_q.ticks - 1'b1;
                end
            end
            ST_SCALE: begin
                if (cnt_sat || (|prod[PROD_W-1:CNT_W])) begin
                    r_d.ovf    = 1'b1;
                    r_d.result = '1;
                end else begin
                    r_d.ovf    = 1'b0;
                    r_d.result = prod[CNT_W-1:0];
                end
                r_d.state = ST_DONE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign gate_o   = (r_q.state == ST_GATE);
    assign done     = (r_q.state == ST_DONE);
    assign overflow = r_q.ovf;
    assign result   = r_q.result;

    // R3: the window opens only just after a timebase boundary
    p_gate_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> $past(tick));

    // R7: a finished result holds until a new start
    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(result) && $stable(overflow)));

    // R2: an accepted start drops done on the next cycle
    p_start_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !done);

    // R8: a start inside the window does not restart the sequence
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o && start) |=> (gate_o || r_q.state == ST_SCALE));

    // R5: done is reached only through the scaling step
    p_done_after_scale_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(r_q.state) == ST_SCALE));

endmodule

// File: tb/freq_counter_test.sv
`timescale 1ns/1ps
module freq_counter_test;

    localparam int CNT_W   = 8;
    localparam int SHIFT   = 2;
    localparam int T_LONG  = 200;
    localparam int T_MID   = 5;
    localparam int T_SHORT = 4;
    localparam int F_MID   = 40;
    localparam int F_SHORT = 50;
    localparam int MAXV    = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sig_in = 1'b0;
    logic             start = 1'b0;
    logic [1:0]       gate_sel = 2'b00;
    logic             gate_o;
    logic             done;
    logic             overflow;
    logic [CNT_W-1:0] result;

    int n_checks = 0;
    int n_fail   = 0;

    int   period_v = 0;
    logic level_v  = 1'b0;
    int   ph       = 0;

    freq_counter #(
        .CNT_W(CNT_W), .TB_SHIFT(SHIFT),
        .TICKS_LONG(T_LONG), .TICKS_MID(T_MID), .TICKS_SHORT(T_SHORT),
        .SCALE_MID(F_MID), .SCALE_SHORT(F_SHORT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .start(start),
        .gate_sel(gate_sel), .gate_o(gate_o), .done(done),
        .overflow(overflow), .result(result)
    );

    always #4 clk = ~clk;

    // stimulus generator: square wave of period_v cycles, or a fixed level
    always @(negedge clk) begin
        if (period_v == 0) begin
            sig_in <= level_v;
        end else begin
            sig_in <= (ph < period_v / 2);
            ph     <= (ph + 1 >= period_v) ? 0 : ph + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int win_cycles(input logic [1:0] sel);
        case (sel)
            2'b01:   return T_MID * (1 << SHIFT);
            2'b10:   return T_SHORT * (1 << SHIFT);
            default: return T_LONG * (1 << SHIFT);
        endcase
    endfunction

    function automatic int factor(input logic [1:0] sel);
        case (sel)
            2'b01:   return F_MID;
            2'b10:   return F_SHORT;
            default: return 1;
        endcase
    endfunction

    // run one measurement; optionally disturb start/gate_sel inside the window
    task automatic measure(input logic [1:0] sel, input int period, input logic lvl,
                           input bit disturb, output int res, output int ovf,
                           output int gcyc, output int done_after_start);
        int guard;
        bit injected;
        period_v = period;
        level_v  = lvl;
        @(negedge clk);
        start    = 1'b1;
        gate_sel = sel;
        @(negedge clk);
        start    = 1'b0;
        done_after_start = done;
        gcyc     = 0;
        guard    = 0;
        injected = 0;
        while (!done && guard < 5000) begin
            @(negedge clk);
            if (gate_o) begin
                gcyc++;
                if (disturb && !injected && gcyc == 3) begin
                    start    = 1'b1;
                    gate_sel = ~sel;
                    injected = 1;
                end else begin
                    start = 1'b0;
                end
            end
            guard++;
        end
        start = 1'b0;
        res = result;
        ovf = overflow;
    endtask

    function automatic void expect_for(input logic [1:0] sel, input int period,
                                       output int eres, output int eovf);
        int c;
        int p;
        c = (period == 0) ? 0 : win_cycles(sel) / period;
        if (c > MAXV) begin
            eres = MAXV; eovf = 1;
        end else begin
            p = c * factor(sel);
            if (p > MAXV) begin eres = MAXV; eovf = 1; end
            else          begin eres = p;    eovf = 0; end
        end
    endfunction

    initial begin
        #(8 * 190000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        int res, ovf, gc, dstart, eres, eovf, held;

        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 done", done, 0);
        check("R1 gate", gate_o, 0);
        check("R1 overflow", overflow, 0);
        check("R1 result", result, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 R4 R5 R6: sweep every period dividing the window, all codes
        for (int s = 0; s < 4; s++) begin
            for (int p = 2; p <= 100; p++) begin
                if (win_cycles(2'(s)) % p == 0) begin
                    measure(2'(s), p, 1'b0, 0, res, ovf, gc, dstart);
                    expect_for(2'(s), p, eres, eovf);
                    check("R2 done low after start", dstart, 0);
                    check("R3 gate length", gc, win_cycles(2'(s)));
                    check("R5 scaled result", res, eres);
                    check("R6 overflow flag", ovf, eovf);
                end
            end
        end

        // R4: a held-high input has no edges in the window
        period_v = 0; level_v = 1'b1;
        repeat (10) @(negedge clk);
        measure(2'b01, 0, 1'b1, 0, res, ovf, gc, dstart);
        check("R4 held level counts nothing", res, 0);

        // R6 then R9: overflowing run followed by a quiet run
        measure(2'b00, 2, 1'b0, 0, res, ovf, gc, dstart);
        check("R6 saturated result", res, MAXV);
        check("R6 saturated flag", ovf, 1);
        measure(2'b00, 0, 1'b0, 0, res, ovf, gc, dstart);
        check("R9 fresh count", res, 0);
        check("R9 fresh overflow", ovf, 0);

        // R7: result holds while the input changes and no start arrives
        measure(2'b10, 8, 1'b0, 0, res, ovf, gc, dstart);
        check("R7 baseline", res, 100);
        period_v = 2;
        repeat (60) @(negedge clk);
        held = result;
        check("R7 result held", held, 100);
        check("R7 done held", done, 1);
        check("R7 overflow held", overflow, 0);

        // R8: stray start and code change inside the window
        measure(2'b01, 5, 1'b0, 1, res, ovf, gc, dstart);
        check("R8 window kept", gc, win_cycles(2'b01));
        check("R8 factor kept", res, 4 * F_MID);
        measure(2'b00, 8, 1'b0, 1, res, ovf, gc, dstart);
        check("R8 long window kept", gc, win_cycles(2'b00));
        check("R8 long factor kept", res, 100);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule